// File: doc/BRIEF.md
# Dual-Channel Event and Timebase Timer

This peripheral holds two counting channels behind a small 32-bit register bus. Both channels count pulses of a single reference tick enable, and each channel has its own power-of-four prescaler. The first channel is a one-shot event timer. Software loads a compare value, clears the counter and starts the channel. The counter then climbs until it reaches the compare value, raises a sticky event flag and parks there. The flag drives the interrupt output unless the mask bit blocks it.

The second channel is a free-running timebase of `CH2_W` bits, 64 by default. Its lower `CH2_LO_W` bits are read directly. Reading them also copies the upper bits into a high buffer, so a following read of that buffer yields a matching pair even if the counter moved between the two bus accesses. Enables use separate set and clear registers, and the counter clear is a write-one strobe. Software can therefore start, stop or zero one channel without a read-modify-write.

Top module: `dual_chan_timer`

## Requirements
- R1: After reset the prescale fields, both enables, both counters, the compare value, the high buffer and the event flag are 0. The mask bit is 1 and `irq` is low.
- R2: Offset 0x00 holds the first channel's prescale code in bits [1:0] and the second channel's in bits [3:2]. For code n in 0..2, an enabled channel advances once per 4^n tick pulses, and code 3 behaves as code 2 (divide by 16).
- R3: Offset 0x34 is enable-set and offset 0x38 is enable-clear. Bit 0 selects the first channel and bit 1 the second, and zero bits are ignored. A stopped counter keeps its value. A read of 0x34 returns the enable bits, and a read of 0x38 returns 0.
- R4: Writing 1 to bit 0 of offset 0x08 zeroes the first counter and restarts its prescale phase, and bit 1 does the same for the second channel. A clear beats a count step in the same cycle, and zero bits have no effect.
- R5: The first counter stops advancing while it equals the compare value (offset 0x14). The event flag (offset 0x0C, bit 0) sets in the same clock as the step that brings the counter onto the compare value, and only then.
- R6: Writing 0 to bit 0 of offset 0x0C clears the flag, and writing 1 leaves it unchanged. If a new event and a clear fall in the same cycle, the event wins.
- R7: `irq` is high exactly when the flag is 1 and the mask bit (offset 0x10, bit 0) is 0.
- R8: The second counter advances by one per prescaled step and wraps from all-ones to zero.
- R9: A read of offset 0x20 returns the low `CH2_LO_W` bits of the second counter. In the same clock it captures the remaining upper bits into the buffer at offset 0x24. That buffer changes on no other event.
- R10: The compare register reads back its full width. Offset 0x18 reads the first counter. Writes to count offsets are ignored, and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick, one pulse per counting opportunity |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used for the high-word capture) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Event interrupt, level |

## Verification
The bench first holds the tick high and runs the channels at fixed prescale codes. Any error in the step rate then shows as a plain count mismatch, and code 3 is told apart from code 2 only by an identical count. It then sets the compare value a few steps ahead of the event counter, which separates a correct park-and-flag from a counter that runs past, flags twice or never flags. The low/high pair is read while the timebase runs with a narrowed low word, so the upper bits change often and a missing or late capture becomes visible. Finally, randomized bursts of writes and reads with a gappy tick catch same-cycle clashes between clear, step, flag set and flag clear.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int unsigned OFF_CLKCTL  = 'h00;
   localparam int unsigned OFF_CLEAR   = 'h08;
   localparam int unsigned OFF_FLAG    = 'h0C;
   localparam int unsigned OFF_MASK    = 'h10;
   localparam int unsigned OFF_CMP     = 'h14;
   localparam int unsigned OFF_C1CNT   = 'h18;
   localparam int unsigned OFF_C2LO    = 'h20;
   localparam int unsigned OFF_C2HI    = 'h24;
   localparam int unsigned OFF_ENSET   = 'h34;
   localparam int unsigned OFF_ENCLR   = 'h38;

   localparam int unsigned NUM_CH      = 2;
   localparam int unsigned PSEL_W      = 2;

   typedef enum logic [PSEL_W-1:0] {
      PS_DIV1  = 2'd0,
      PS_DIV4  = 2'd1,
      PS_DIV16 = 2'd2,
      PS_ALT16 = 2'd3
   } psel_e;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
   import dct_pkg::*;
#(
   parameter int MAX_LOG4 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              restart,
   input  logic              tick_in,
   input  logic [PSEL_W-1:0] sel,
   output logic              step
);
   if (MAX_LOG4 < 0 || MAX_LOG4 > 3) begin : g_bad_max
      $error("dct_prescaler: MAX_LOG4 must be 0..3");
   end

   if (MAX_LOG4 == 0) begin : g_bypass
      logic [PSEL_W-1:0] unused_sel;
      logic              unused_rs;
      assign unused_sel = sel;
      assign unused_rs  = restart ^ clk ^ rst_n;
      assign step       = en & tick_in;
   end else begin : g_divide
      localparam int CNT_W = 2 * MAX_LOG4;
      logic [CNT_W-1:0]  phase_q;
      logic [PSEL_W-1:0] eff;
      logic [CNT_W-1:0]  div_m1;

      always_comb begin
         eff    = (sel > PSEL_W'(MAX_LOG4)) ? PSEL_W'(MAX_LOG4) : sel;
         div_m1 = CNT_W'((32'd1 << (2 * eff)) - 32'd1);
      end

      assign step = en & tick_in & (phase_q >= div_m1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (!en || restart) begin
            phase_q <= '0;
         end else if (tick_in) begin
            phase_q <= step ? '0 : phase_q + CNT_W'(1);
         end
      end

      // after a step the phase restarts, so a divided channel cannot step twice in a row
      assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (step && eff != '0) |=> (!step || eff == '0))
         else $error("R2: divided prescaler stepped on consecutive cycles");
   end
endmodule

// File: rtl/dct_oneshot.sv
module dct_oneshot #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clr,
   input  logic [W-1:0] cmp,
   input  logic         flag_clr,
   output logic [W-1:0] cnt,
   output logic         flag
);
   if (W < 2) begin : g_bad_w
      $error("dct_oneshot: W must be at least 2");
   end

   logic [W-1:0] nxt;
   logic         at_cmp;
   logic         adv;
   logic         hit;

   always_comb begin
      nxt    = cnt + W'(1);
      at_cmp = (cnt == cmp);
      adv    = step && !clr && !at_cmp;
      hit    = adv && (nxt == cmp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (flag_clr) begin
         flag <= 1'b0;
      end
   end

   assert_park_at_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cmp && !clr) |=> (cnt == $past(cnt)))
      else $error("R5: event counter moved off the compare value");

   assert_flag_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == $past(cnt) + W'(1)))
      else $error("R5: flag rose without a counter step");
endmodule

// File: rtl/dct_freerun.sv
module dct_freerun #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("dct_freerun: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + W'(1);
      end
   end

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> (cnt == $past(cnt)))
      else $error("R3: timebase moved without a step");

   assert_step_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (cnt == $past(cnt) + W'(1)))
      else $error("R8: timebase did not advance by one");
endmodule

// File: rtl/dual_chan_timer.sv
module dual_chan_timer
   import dct_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CH1_W    = 32,
   parameter int CH2_W    = 64,
   parameter int CH2_LO_W = 32,
   parameter int MAX_LOG4 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int HI_W = CH2_W - CH2_LO_W;

   if (DATA_W < 8) begin : g_bad_data
      $error("dual_chan_timer: DATA_W must be at least 8");
   end
   if (CH1_W > DATA_W) begin : g_bad_ch1
      $error("dual_chan_timer: CH1_W wider than the bus");
   end
   if (CH2_LO_W > DATA_W || HI_W < 1 || HI_W > DATA_W) begin : g_bad_ch2
      $error("dual_chan_timer: channel 2 split does not fit the bus");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("dual_chan_timer: ADDR_W too small for the register map");
   end

   // ---------------- register decode ----------------
   logic wr_clkctl, wr_clear, wr_flag, wr_mask, wr_cmp, wr_enset, wr_enclr;
   logic rd_lo;

   always_comb begin
      wr_clkctl = bus_we && (bus_addr == ADDR_W'(OFF_CLKCTL));
      wr_clear  = bus_we && (bus_addr == ADDR_W'(OFF_CLEAR));
      wr_flag   = bus_we && (bus_addr == ADDR_W'(OFF_FLAG));
      wr_mask   = bus_we && (bus_addr == ADDR_W'(OFF_MASK));
      wr_cmp    = bus_we && (bus_addr == ADDR_W'(OFF_CMP));
      wr_enset  = bus_we && (bus_addr == ADDR_W'(OFF_ENSET));
      wr_enclr  = bus_we && (bus_addr == ADDR_W'(OFF_ENCLR));
      rd_lo     = bus_re && (bus_addr == ADDR_W'(OFF_C2LO));
   end

   // ---------------- control state ----------------
   logic [NUM_CH*PSEL_W-1:0] psel_q;
   logic [NUM_CH-1:0]        en_q;
   logic                     mask_q;
   logic [CH1_W-1:0]         cmp_q;
   logic [HI_W-1:0]          hibuf_q;
   logic [NUM_CH-1:0]        clr_pulse;
   logic                     flag_clr;

   assign clr_pulse = wr_clear ? bus_wdata[NUM_CH-1:0] : '0;
   assign flag_clr  = wr_flag && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q <= '0;
         en_q   <= '0;
         mask_q <= 1'b1;
         cmp_q  <= '0;
      end else begin
         if (wr_clkctl) psel_q <= bus_wdata[NUM_CH*PSEL_W-1:0];
         if (wr_enset)  en_q   <= en_q | bus_wdata[NUM_CH-1:0];
         if (wr_enclr)  en_q   <= en_q & ~bus_wdata[NUM_CH-1:0];
         if (wr_mask)   mask_q <= bus_wdata[0];
         if (wr_cmp)    cmp_q  <= bus_wdata[CH1_W-1:0];
      end
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^bus_wdata[DATA_W-1:NUM_CH*PSEL_W];

   // ---------------- prescalers, one per channel ----------------
   logic [NUM_CH-1:0] step;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_psc
      dct_prescaler #(.MAX_LOG4(MAX_LOG4)) psc_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_q[c]),
         .restart (clr_pulse[c]),
         .tick_in (tick_en),
         .sel     (psel_q[c*PSEL_W +: PSEL_W]),
         .step    (step[c])
      );
   end

   // ---------------- channels ----------------
   logic [CH1_W-1:0] c1_cnt;
   logic             flag;
   logic [CH2_W-1:0] c2_cnt;

   dct_oneshot #(.W(CH1_W)) ev_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step[0]),
      .clr      (clr_pulse[0]),
      .cmp      (cmp_q),
      .flag_clr (flag_clr),
      .cnt      (c1_cnt),
      .flag     (flag)
   );

   dct_freerun #(.W(CH2_W)) tb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step[1]),
      .clr   (clr_pulse[1]),
      .cnt   (c2_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hibuf_q <= '0;
      end else if (rd_lo) begin
         hibuf_q <= c2_cnt[CH2_W-1:CH2_LO_W];
      end
   end

   assign irq = flag & ~mask_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFF_CLKCTL): bus_rdata = DATA_W'(psel_q);
         ADDR_W'(OFF_FLAG):   bus_rdata = DATA_W'(flag);
         ADDR_W'(OFF_MASK):   bus_rdata = DATA_W'(mask_q);
         ADDR_W'(OFF_CMP):    bus_rdata = DATA_W'(cmp_q);
         ADDR_W'(OFF_C1CNT):  bus_rdata = DATA_W'(c1_cnt);
         ADDR_W'(OFF_C2LO):   bus_rdata = DATA_W'(c2_cnt[CH2_LO_W-1:0]);
         ADDR_W'(OFF_C2HI):   bus_rdata = DATA_W'(hibuf_q);
         ADDR_W'(OFF_ENSET):  bus_rdata = DATA_W'(en_q);
         default:             bus_rdata = '0;
      endcase
   end

   assert_hibuf_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(hibuf_q))
      else $error("R9: high buffer changed without a low-word read");

   assert_flag_falls_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(flag_clr))
      else $error("R6: flag cleared without a software write of 0");

   assert_irq_needs_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask && bus_wdata[0]) |=> !irq)
      else $error("R7: interrupt asserted while masked");
endmodule

// File: tb/dual_chan_timer_tb_top.sv
`timescale 1ns/1ps
module dual_chan_timer_tb_top;
   localparam int AW = 8, DW = 32, C1W = 32, C2W = 16, LOW = 8;
   localparam int HW = C2W - LOW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic          bus_re = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;
   bit tick_always = 1'b1;

   always #2 clk = ~clk;

   dual_chan_timer #(.ADDR_W(AW), .DATA_W(DW), .CH1_W(C1W), .CH2_W(C2W),
                     .CH2_LO_W(LOW), .MAX_LOG4(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq));

   // ---------------- reference model from the requirements ----------------
   logic [3:0]     m_ctrl;
   logic [1:0]     m_en;
   logic           m_mask, m_flag;
   logic [C1W-1:0] m_cmp, m_c1;
   logic [C2W-1:0] m_c2;
   logic [HW-1:0]  m_hib;
   logic [3:0]     m_ph1, m_ph2;

   function automatic logic [3:0] span_m1(input logic [1:0] code);
      return (code == 2'd0) ? 4'd0 : (code == 2'd1) ? 4'd3 : 4'd15;  // R2: code 3 as 16
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= '0; m_en <= '0; m_mask <= 1'b1; m_flag <= 1'b0;
         m_cmp <= '0; m_c1 <= '0; m_c2 <= '0; m_hib <= '0; m_ph1 <= '0; m_ph2 <= '0;
      end else begin
         logic s1, s2, c1clr, c2clr, fclr, hit;
         c1clr = bus_we && bus_addr == 8'h08 && bus_wdata[0];
         c2clr = bus_we && bus_addr == 8'h08 && bus_wdata[1];
         s1 = m_en[0] && tick_en && (m_ph1 >= span_m1(m_ctrl[1:0]));
         s2 = m_en[1] && tick_en && (m_ph2 >= span_m1(m_ctrl[3:2]));
         if (!m_en[0] || c1clr) m_ph1 <= '0; else if (tick_en) m_ph1 <= s1 ? 4'd0 : m_ph1 + 4'd1;
         if (!m_en[1] || c2clr) m_ph2 <= '0; else if (tick_en) m_ph2 <= s2 ? 4'd0 : m_ph2 + 4'd1;
         hit = s1 && !c1clr && (m_c1 != m_cmp) && (m_c1 + 1 == m_cmp);
         if (c1clr) m_c1 <= '0; else if (s1 && m_c1 != m_cmp) m_c1 <= m_c1 + 1;
         if (c2clr) m_c2 <= '0; else if (s2) m_c2 <= m_c2 + 1;
         fclr = bus_we && bus_addr == 8'h0C && !bus_wdata[0];
         if (hit) m_flag <= 1'b1; else if (fclr) m_flag <= 1'b0;
         if (bus_re && bus_addr == 8'h20) m_hib <= m_c2[C2W-1:LOW];
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_ctrl <= bus_wdata[3:0];
               8'h10: m_mask <= bus_wdata[0];
               8'h14: m_cmp  <= bus_wdata;
               8'h34: m_en   <= m_en | bus_wdata[1:0];
               8'h38: m_en   <= m_en & ~bus_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      case (a)
         8'h00: return DW'(m_ctrl);
         8'h0C: return DW'(m_flag);
         8'h10: return DW'(m_mask);
         8'h14: return m_cmp;
         8'h18: return m_c1;
         8'h20: return DW'(m_c2[LOW-1:0]);
         8'h24: return DW'(m_hib);
         8'h34: return DW'(m_en);
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [AW-1:0] a);
      case (a)
         8'h00: return "R2";
         8'h0C: return "R5";
         8'h10: return "R7";
         8'h14: return "R10";
         8'h18: return "R5";
         8'h20: return "R8";
         8'h24: return "R9";
         8'h34: return "R3";
         default: return "R10";
      endcase
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
      vectors++;
      if (act !== expv) begin
         misses++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0; bus_re = 1'b1;
      #1;
      chk(req, bus_rdata, exp_read(a));
      chk("R7", DW'(irq), DW'(m_flag & ~m_mask));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_we = 1'b0; bus_re = 1'b0;
      end
   endtask

   always @(negedge clk) tick_en <= tick_always ? 1'b1 : 1'($urandom % 2);

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 200000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [AW-1:0] addrs [12];
      void'($urandom(32'd20240611));
      addrs = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h34, 8'h38, 8'h04, 8'h3C};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      foreach (addrs[i]) rd(addrs[i], "R1");
      chk("R1", DW'(bus_rdata), 32'd0);
      chk("R1 mask", DW'(dut_i.bus_rdata), DW'(0)); // unused address 0x3C last read
      idle(1);

      // R2 / R3: timebase at divide by 4, then divide by 16 via code 3
      wr(8'h00, 32'h4); wr(8'h34, 32'h2); idle(37); rd(8'h20, "R2");
      wr(8'h00, 32'hC); wr(8'h08, 32'h2); idle(50); rd(8'h20, "R2");
      chk("R2", DW'(m_c2), DW'(3));
      wr(8'h34, 32'h0); idle(3); rd(8'h34, "R3");
      wr(8'h38, 32'h2); idle(30); rd(8'h20, "R3"); idle(40); rd(8'h20, "R3");
      rd(8'h38, "R3");

      // R5 / R6 / R7: one-shot event
      wr(8'h00, 32'h0); wr(8'h14, 32'd10); wr(8'h10, 32'h0); wr(8'h08, 32'h1);
      wr(8'h34, 32'h1); idle(15);
      rd(8'h18, "R5"); chk("R5", bus_rdata, 32'd10);
      rd(8'h0C, "R5"); chk("R7", DW'(irq), 32'd1);
      wr(8'h0C, 32'h1); idle(2); rd(8'h0C, "R6");
      wr(8'h10, 32'h1); idle(1); rd(8'h10, "R7"); chk("R7", DW'(irq), 32'd0);
      wr(8'h10, 32'h0); wr(8'h0C, 32'h0); idle(5); rd(8'h0C, "R6"); rd(8'h18, "R5");
      wr(8'h14, 32'd14); idle(8); rd(8'h0C, "R5"); rd(8'h18, "R5");

      // R4: clear zero bits do nothing, bit 0 zeroes the event counter
      wr(8'h08, 32'h0); idle(1); rd(8'h18, "R4");
      wr(8'h08, 32'h1); idle(1); rd(8'h18, "R4");

      // R10: compare readback, read-only and unused offsets
      wr(8'h14, 32'hDEADBEEF); idle(1); rd(8'h14, "R10");
      wr(8'h18, 32'h12345678); wr(8'h20, 32'hFF); wr(8'h04, 32'h55);
      idle(1); rd(8'h18, "R10"); rd(8'h04, "R10"); rd(8'h3C, "R10");

      // R8 / R9: timebase wrap and coherent pairs
      wr(8'h38, 32'h1); wr(8'h00, 32'h0); wr(8'h08, 32'h2); wr(8'h34, 32'h2);
      for (int k = 0; k < 40; k++) begin
         idle(1 + ($urandom % 40)); rd(8'h20, "R9"); idle($urandom % 5); rd(8'h24, "R9");
      end
      idle((1 << C2W) - 1700);
      for (int k = 0; k < 10; k++) begin
         rd(8'h20, "R8"); rd(8'h24, "R8"); idle(300);
      end

      // random mix
      tick_always = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         int op;
         op = $urandom % 14;
         case (op)
            0: wr(8'h00, 32'($urandom % 16));
            1: wr(8'h08, 32'($urandom % 4));
            2: wr(8'h0C, 32'($urandom % 2));
            3: wr(8'h10, 32'($urandom % 2));
            4: wr(8'h14, m_c1 + 32'($urandom % 24));
            5: wr(8'h34, 32'($urandom % 4));
            6: if ($urandom % 3 == 0) wr(8'h38, 32'($urandom % 4)); else idle(1);
            default: begin
               logic [AW-1:0] a;
               a = addrs[$urandom % 12];
               rd(a, req_of(a));
            end
         endcase
      end
      idle(2);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule